// File: doc/BRIEF.md
# Host Clock Sleep Gate

This block decides when the clock handed to an external host may run and when a commanded power mode actually takes effect. It watches the commanded mode, a low-frequency-clock enable, a two-bit tail select and the interrupt flags. From these it drives a clock-enable for a downstream glitch-free gate, the effective mode and the enable of the main oscillator.

When sleep is commanded and the low-frequency clock is not in use, the block can keep the host clock running for a programmable tail of extra cycles, so the host can finish its work before the clock stops. A pending, unread interrupt overrides everything: the host clock and oscillator stay on, and the effective mode is frozen until the status is read. In the cycle of the read, the commanded mode is applied as if no interrupt were present.

Top module: `sleep_clock_gate`

## Requirements
- R1: While reset is high, `mode_eff` is 2'b00 (active), `host_clk_en` is 1 and `osc_en` is 1.
- R2: Mode codes are 2'b00 active, 2'b01 ready, 2'b10 tune and 2'b11 sleep. A non-sleep command sampled with no hold in force appears on `mode_eff` after that rising edge.
- R3: With `lfclk_en` = 0, sleep commanded from the running state keeps `host_clk_en` high for exactly 0, 128, 256 or 512 further cycles, for `tail_sel` 2'b00, 2'b01, 2'b10 and 2'b11. The tail counts from the first rising edge that sees the command.
- R4: When the tail ends (or at once, for a zero tail), `host_clk_en` and `osc_en` go low and `mode_eff` becomes 2'b11 in the same cycle.
- R5: With `lfclk_en` = 1, a sleep command skips the tail. `mode_eff` becomes 2'b11 and `osc_en` goes low after the next rising edge, but `host_clk_en` stays high.
- R6: A hold is `irq_pending` = 1 with `status_rd` = 0. A hold sampled on a rising edge leaves `host_clk_en` and `osc_en` high and `mode_eff` unchanged for the following cycle, whatever the command.
- R7: A sampled `status_rd` = 1 cancels the hold in that cycle, and the commanded mode, including sleep, is applied at that edge.
- R8: A non-sleep command during the tail ends it. The clock stays on, the new mode is applied, and a later sleep command starts a full tail again.
- R9: A hold while sleeping turns `osc_en` and `host_clk_en` back on after the next edge.
- R10: `host_clk_en` changes only on a falling edge of `clk`, never on a rising one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cmd | input | 2 | Commanded mode (00 active, 01 ready, 10 tune, 11 sleep) |
| lfclk_en | input | 1 | Low-frequency clock in use; host clock kept running in sleep |
| tail_sel | input | 2 | Extra clock cycles before shutdown: 0/128/256/512 |
| irq_pending | input | 1 | Interrupt raised and not yet read |
| status_rd | input | 1 | Strobe: interrupt status is being read this cycle |
| host_clk_en | output | 1 | Enable for the host clock gate, updated on falling edges |
| mode_eff | output | 2 | Mode currently applied |
| osc_en | output | 1 | Main oscillator enable |

## Verification
Mode, oscillator and state decisions register on the rising edge after the inputs are sampled. `mode_eff` and `osc_en` are therefore due one rising edge after a stimulus. `host_clk_en` follows half a period later, at the next falling edge. The bench drives inputs 7 ns after a rising edge and compares all three outputs 7 ns after the next rising edge, once that falling edge has passed. One nanosecond after each rising edge it also confirms that `host_clk_en` still holds the value seen at the previous sample. Tail lengths are measured by counting samples with the clock enable high, starting from the first edge that sees sleep.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'b00,
        MODE_READY  = 2'b01,
        MODE_TUNE   = 2'b10,
        MODE_SLEEP  = 2'b11
    } pwr_mode_e;

    typedef enum logic [1:0] {
        GS_RUN  = 2'b00,
        GS_TAIL = 2'b01,
        GS_OFF  = 2'b10
    } gate_state_e;

    // Number of extra host clock cycles for a tail select code.
    function automatic int unsigned tail_cycles(input logic [1:0] sel,
                                                input int unsigned unit);
        case (sel)
            2'b00:   return 0;
            2'b01:   return unit;
            2'b10:   return unit * 2;
            default: return unit * 4;
        endcase
    endfunction

endpackage

// File: rtl/sleep_tail_cnt.sv
module sleep_tail_cnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len_m1,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= len_m1;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == '0);
endmodule

// File: rtl/sleep_mode_fsm.sv
module sleep_mode_fsm
    import sleep_gate_pkg::*;
#(
    parameter int TAIL_UNIT = 128,
    parameter int CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_cmd,
    input  logic             lfclk_en,
    input  logic [1:0]       tail_sel,
    input  logic             hold,
    input  logic             tail_last,
    output gate_state_e      state,
    output logic [1:0]       mode_eff,
    output logic             tail_load,
    output logic [CNT_W-1:0] tail_len_m1
);
    int unsigned  tail_n;
    logic         sleep_req;
    logic         use_tail;
    gate_state_e  state_nx;
    logic [1:0]   mode_nx;

    always_comb begin
        tail_n      = tail_cycles(tail_sel, TAIL_UNIT);
        sleep_req   = (mode_cmd == MODE_SLEEP);
        use_tail    = !lfclk_en && (tail_n != 0);
        tail_len_m1 = (tail_n == 0) ? '0 : CNT_W'(tail_n - 1);
        tail_load   = (state == GS_RUN) && !hold && sleep_req && use_tail;
    end

    always_comb begin
        state_nx = state;
        mode_nx  = mode_eff;
        if (hold) begin
            // Interrupt unread: keep clock alive, freeze the mode.
            state_nx = GS_RUN;
        end else if (!sleep_req) begin
            state_nx = GS_RUN;
            mode_nx  = mode_cmd;
        end else begin
            case (state)
                GS_RUN: begin
                    if (use_tail) begin
                        state_nx = GS_TAIL;
                    end else begin
                        state_nx = GS_OFF;
                        mode_nx  = MODE_SLEEP;
                    end
                end
                GS_TAIL: begin
                    if (tail_last) begin
                        state_nx = GS_OFF;
                        mode_nx  = MODE_SLEEP;
                    end
                end
                default: begin
                    state_nx = GS_OFF;
                    mode_nx  = MODE_SLEEP;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= GS_RUN;
            mode_eff <= MODE_ACTIVE;
        end else begin
            state    <= state_nx;
            mode_eff <= mode_nx;
        end
    end
endmodule

// File: rtl/sleep_clk_gate.sv
module sleep_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic want,
    output logic en
);
    // Updated while clk is low so the downstream AND gate never sees a
    // partial pulse.
    always_ff @(negedge clk) begin
        if (rst) en <= 1'b1;
        else     en <= want;
    end
endmodule

// File: rtl/sleep_clock_gate.sv
module sleep_clock_gate
    import sleep_gate_pkg::*;
#(
    parameter int TAIL_UNIT = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_cmd,
    input  logic       lfclk_en,
    input  logic [1:0] tail_sel,
    input  logic       irq_pending,
    input  logic       status_rd,
    output logic       host_clk_en,
    output logic [1:0] mode_eff,
    output logic       osc_en
);
    localparam int CNT_W = $clog2(TAIL_UNIT * 4);

    gate_state_e      state;
    logic             hold;
    logic             tail_load;
    logic             tail_last;
    logic [CNT_W-1:0] tail_len_m1;
    logic             clk_want;

    assign hold = irq_pending && !status_rd;

    sleep_mode_fsm #(
        .TAIL_UNIT (TAIL_UNIT),
        .CNT_W     (CNT_W)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .mode_cmd    (mode_cmd),
        .lfclk_en    (lfclk_en),
        .tail_sel    (tail_sel),
        .hold        (hold),
        .tail_last   (tail_last),
        .state       (state),
        .mode_eff    (mode_eff),
        .tail_load   (tail_load),
        .tail_len_m1 (tail_len_m1)
    );

    sleep_tail_cnt #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .load   (tail_load),
        .len_m1 (tail_len_m1),
        .run    (state == GS_TAIL),
        .last   (tail_last)
    );

    assign osc_en   = (state != GS_OFF);
    assign clk_want = (state != GS_OFF) || lfclk_en;

    sleep_clk_gate gate_i (
        .clk  (clk),
        .rst  (rst),
        .want (clk_want),
        .en   (host_clk_en)
    );
endmodule

// File: rtl/sleep_gate_chk.sv
module sleep_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_cmd,
    input logic       lfclk_en,
    input logic       irq_pending,
    input logic       status_rd,
    input logic       host_clk_en,
    input logic [1:0] mode_eff,
    input logic       osc_en
);
    // R4
    clk_off_only_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        !host_clk_en |-> mode_eff == 2'b11);

    // R4
    osc_off_only_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> mode_eff == 2'b11);

    // R6
    hold_keeps_clocks_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pending && !status_rd) |=> (host_clk_en && osc_en));

    // R6
    hold_freezes_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pending && !status_rd) |=> mode_eff == $past(mode_eff));

    // R2
    awake_cmd_applied_chk: assert property (@(posedge clk) disable iff (rst)
        (!(irq_pending && !status_rd) && mode_cmd != 2'b11) |=> mode_eff == $past(mode_cmd));

    // R5
    lf_clock_kept_chk: assert property (@(posedge clk) disable iff (rst)
        lfclk_en |=> host_clk_en);
endmodule

bind sleep_clock_gate sleep_gate_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_cmd    (mode_cmd),
    .lfclk_en    (lfclk_en),
    .irq_pending (irq_pending),
    .status_rd   (status_rd),
    .host_clk_en (host_clk_en),
    .mode_eff    (mode_eff),
    .osc_en      (osc_en)
);

// File: tb/sleep_clock_gate_tb_top.sv
`timescale 1ns/1ps
module sleep_clock_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_cmd;
    logic       lfclk_en;
    logic [1:0] tail_sel;
    logic       irq_pending;
    logic       status_rd;
    logic       host_clk_en;
    logic [1:0] mode_eff;
    logic       osc_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model state: 0 run, 1 tail, 2 off
    int       m_state;
    int       m_left;
    logic [1:0] m_mode;
    logic     last_en;

    always #5 clk = ~clk;

    sleep_clock_gate dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_cmd    (mode_cmd),
        .lfclk_en    (lfclk_en),
        .tail_sel    (tail_sel),
        .irq_pending (irq_pending),
        .status_rd   (status_rd),
        .host_clk_en (host_clk_en),
        .mode_eff    (mode_eff),
        .osc_en      (osc_en)
    );

    function automatic int tail_of(input logic [1:0] s);
        case (s)
            2'd0: return 0;
            2'd1: return 128;
            2'd2: return 256;
            default: return 512;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit hold;
        hold = irq_pending && !status_rd;
        if (hold) begin
            m_state = 0;
        end else if (mode_cmd != 2'b11) begin
            m_state = 0;
            m_mode  = mode_cmd;
        end else if (m_state == 0) begin
            if (lfclk_en || tail_of(tail_sel) == 0) begin
                m_state = 2;
                m_mode  = 2'b11;
            end else begin
                m_state = 1;
                m_left  = tail_of(tail_sel);
            end
        end else if (m_state == 1) begin
            m_left--;
            if (m_left == 0) begin
                m_state = 2;
                m_mode  = 2'b11;
            end
        end
    endtask

    // Inputs are set by the caller before this; we are 7 ns after a rising edge.
    task automatic step(input string tag);
        bit lf_now;
        lf_now = lfclk_en;
        @(posedge clk);
        #1;
        chk("R10 no change at rising edge", host_clk_en, last_en);
        model_edge();
        #6;
        chk(tag, mode_eff, m_mode);
        chk(tag, osc_en, (m_state != 2));
        chk(tag, host_clk_en, (m_state != 2) || lf_now);
        last_en = host_clk_en;
    endtask

    task automatic drive(input logic [1:0] c, input logic lf, input logic [1:0] ts,
                         input logic irq, input logic rd);
        mode_cmd = c; lfclk_en = lf; tail_sel = ts; irq_pending = irq; status_rd = rd;
    endtask

    // Sleep with a tail; count how many samples keep the clock on.
    task automatic tail_run(input logic [1:0] ts, input string tag);
        int on_cnt;
        on_cnt = 0;
        drive(2'b11, 1'b0, ts, 1'b0, 1'b0);
        for (int i = 0; i < 600; i++) begin
            step(tag);
            if (host_clk_en) on_cnt++;
            else break;
        end
        chk(tag, on_cnt, tail_of(ts));
        chk("R4 sleep mode at shutdown", mode_eff, 2'b11);
        chk("R4 oscillator off", osc_en, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        drive(2'b00, 1'b0, 2'b00, 1'b0, 1'b0);
        m_state = 0; m_left = 0; m_mode = 2'b00;
        repeat (3) @(posedge clk);
        #7;
        chk("R1 reset mode", mode_eff, 2'b00);
        chk("R1 reset clock enable", host_clk_en, 1'b1);
        chk("R1 reset oscillator", osc_en, 1'b1);
        last_en = host_clk_en;
        rst = 1'b0;

        // R2: each awake mode
        drive(2'b01, 0, 2'b00, 0, 0); step("R2 ready");
        chk("R2 ready code", mode_eff, 2'b01);
        drive(2'b10, 0, 2'b00, 0, 0); step("R2 tune");
        chk("R2 tune code", mode_eff, 2'b10);
        drive(2'b00, 0, 2'b00, 0, 0); step("R2 active");

        // R3/R4: each tail length
        tail_run(2'b00, "R3 tail 0");
        drive(2'b00, 0, 2'b00, 0, 0); step("R2 wake");
        tail_run(2'b01, "R3 tail 128");
        drive(2'b01, 0, 2'b00, 0, 0); step("R2 wake");
        tail_run(2'b10, "R3 tail 256");
        drive(2'b00, 0, 2'b00, 0, 0); step("R2 wake");
        tail_run(2'b11, "R3 tail 512");

        // R9: interrupt while asleep
        drive(2'b11, 0, 2'b11, 1, 0); step("R9 wake on irq");
        chk("R9 clock back on", host_clk_en, 1'b1);
        chk("R9 oscillator on", osc_en, 1'b1);
        chk("R6 mode frozen", mode_eff, 2'b11);
        // R7: read lets sleep apply; zero tail gives immediate stop
        drive(2'b11, 0, 2'b00, 1, 1); step("R7 read applies sleep");
        chk("R7 clock off after read", host_clk_en, 1'b0);

        // R5: low-frequency clock kept in sleep
        drive(2'b00, 0, 2'b00, 0, 0); step("R2 wake");
        drive(2'b11, 1, 2'b11, 0, 0); step("R5 lf sleep");
        chk("R5 clock kept", host_clk_en, 1'b1);
        chk("R5 sleep applied without tail", mode_eff, 2'b11);
        chk("R5 oscillator off", osc_en, 1'b0);

        // R6: hold blocks sleep from active
        drive(2'b00, 0, 2'b00, 0, 0); step("R2 wake");
        drive(2'b11, 0, 2'b00, 1, 0);
        for (int i = 0; i < 5; i++) step("R6 hold");
        chk("R6 mode held active", mode_eff, 2'b00);
        chk("R6 clock held", host_clk_en, 1'b1);
        drive(2'b11, 0, 2'b00, 1, 1); step("R7 read");
        chk("R7 sleep after read", mode_eff, 2'b11);

        // R8: abort the tail, then a full tail again
        drive(2'b00, 0, 2'b00, 0, 0); step("R2 wake");
        drive(2'b11, 0, 2'b01, 0, 0);
        for (int i = 0; i < 100; i++) step("R8 partial tail");
        drive(2'b10, 0, 2'b01, 0, 0); step("R8 abort");
        chk("R8 mode applied", mode_eff, 2'b10);
        chk("R8 clock stays", host_clk_en, 1'b1);
        tail_run(2'b01, "R8 full tail again");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom % 8;
            drive((r < 5) ? 2'b11 : 2'(r % 3),
                  ($urandom % 8) == 0,
                  2'($urandom % 4),
                  ($urandom % 40) == 0,
                  ($urandom % 3) == 0);
            step("R2 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule